// File: doc/BRIEF.md
# Page Translation Buffer with Table Walk

This block turns a logical address into a physical one. The logical address is split in two. The upper bits are a page number and the lower `OFF_W` bits are an offset. The block looks up the page number in a small, fully associative buffer that holds page-to-frame pairs. Every entry of the buffer is compared in the same cycle. A match gives the frame number straight away. The physical address is that frame number with the unchanged offset appended below it.

When no entry matches, the block issues one read to memory. The read address is a table base address plus the page number. The returned table entry carries a frame number, a valid flag, a writable flag and an executable flag. A valid entry is written into the buffer, with slots chosen in round-robin order, and the access then completes. A page number that is not below the table length register faults without any memory access. So does an access type that the entry does not permit.

The block handles one translation at a time. A flush input empties the buffer so that a new page table takes effect.

Top module: `tlb_walker`

## Requirements
- R1: The physical address equals the frame number (upper `FRAME_W` bits) followed by the logical offset (lower `OFF_W` bits), unchanged. On a fault the physical address is zero.
- R2: When the page number matches a buffer entry, `resp_valid` is high with `resp_hit`=1 in the cycle after the request is accepted, and no memory read is issued.
- R3: On a miss, `mem_req_valid` rises in the cycle after acceptance with `mem_req_addr` = `ptbase` + page number. It stays high until `mem_resp_valid`, and `resp_valid` (with `resp_hit`=0) follows in the next cycle.
- R4: A page number greater than or equal to `ptlen` gives `resp_fault`=1 in the cycle after acceptance, with no memory read.
- R5: A table entry word holds the frame in bits [FRAME_W-1:0], valid at bit FRAME_W, writable at FRAME_W+1 and executable at FRAME_W+2. An entry with valid=0 faults and is not loaded, so a repeat access reads memory again.
- R6: The access kind is coded 00 read, 01 write, 10 execute, and 11 acts as read. A write to a non-writable page faults, as does an execute on a non-executable page. A read of a valid page never faults on permission. Permissions apply the same way on hits and on misses.
- R7: Refills go to buffer slots in round-robin order. After `ENTRIES` fills following a flush, the next fill evicts the oldest page, while the other pages still hit.
- R8: A cycle with `flush` high clears every buffer entry, so the next access to any page misses.
- R9: `req_ready` is low while a memory read is outstanding and while `flush` is high. After reset, `req_ready` is high and `resp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | VA_W | Logical address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| ptbase | input | MEM_AW | Page table base address |
| ptlen | input | VA_W-OFF_W+1 | Number of legal pages |
| mem_req_valid | output | 1 | Table read outstanding |
| mem_req_addr | output | MEM_AW | Table entry address |
| mem_resp_valid | input | 1 | Table entry returned |
| mem_resp_data | input | FRAME_W+3 | Table entry word |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | FRAME_W+OFF_W | Physical address |
| resp_fault | output | 1 | Access illegal |
| resp_hit | output | 1 | Result came from the buffer |

## Verification
A hit or a length fault produces its result one clock after the accepting edge. A miss raises the memory read one clock after acceptance, and its result comes one clock after the edge at which the memory answer is taken. The bench's memory model answers a fixed number of cycles after it sees the read. It records every read and checks the read address, so the driver can tell whether a walk happened. The monitor samples on falling edges only. It matches each result pulse against the oldest queued expectation, so it needs no fixed latency count, and the driver keeps only one request in flight.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int MEM_AW  = 16,
  parameter int ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [1:0]               req_kind,
  input  logic [MEM_AW-1:0]        ptbase,
  input  logic [VA_W-OFF_W:0]      ptlen,
  output logic                     mem_req_valid,
  output logic [MEM_AW-1:0]        mem_req_addr,
  input  logic                     mem_resp_valid,
  input  logic [FRAME_W+2:0]       mem_resp_data,
  output logic                     resp_valid,
  output logic [FRAME_W+OFF_W-1:0] resp_paddr,
  output logic                     resp_fault,
  output logic                     resp_hit
);
  localparam int PN_W  = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [PN_W-1:0]    ent_pn [ENTRIES];
  logic [FRAME_W-1:0] ent_fr [ENTRIES];
  logic [ENTRIES-1:0] ent_w, ent_x;
  logic [IDX_W-1:0]   rr;

  logic               walking;
  logic [PN_W-1:0]    cur_pn;
  logic [OFF_W-1:0]   cur_off;
  logic [1:0]         cur_kind;

  logic [PN_W-1:0]    req_pn;
  logic [OFF_W-1:0]   req_off;
  logic [ENTRIES-1:0] hit_vec;
  logic [FRAME_W-1:0] hit_fr;
  logic               hit_w, hit_x, accept, len_bad, refill;

  function automatic logic denied(input logic w, input logic x, input logic [1:0] k);
    return (k == 2'b01 && !w) || (k == 2'b10 && !x);
  endfunction

  assign req_pn        = req_vaddr[VA_W-1:OFF_W];
  assign req_off       = req_vaddr[OFF_W-1:0];
  assign req_ready     = !walking && !flush;
  assign accept        = req_valid && req_ready;
  assign len_bad       = {1'b0, req_pn} >= ptlen;
  assign mem_req_valid = walking;
  assign refill        = walking && mem_resp_valid && mem_resp_data[FRAME_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent_v[i] && (ent_pn[i] == req_pn);
  end

  always_comb begin
    hit_fr = '0;
    hit_w  = 1'b0;
    hit_x  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_fr = hit_fr | ent_fr[i];
        hit_w  = hit_w | ent_w[i];
        hit_x  = hit_x | ent_x[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v        <= '0;
      rr           <= '0;
      walking      <= 1'b0;
      resp_valid   <= 1'b0;
      resp_fault   <= 1'b0;
      resp_hit     <= 1'b0;
      resp_paddr   <= '0;
      mem_req_addr <= '0;
      cur_pn       <= '0;
      cur_off      <= '0;
      cur_kind     <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (flush) ent_v <= '0;
      if (accept) begin
        cur_pn   <= req_pn;
        cur_off  <= req_off;
        cur_kind <= req_kind;
        if (len_bad) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_fault <= 1'b1;
          resp_paddr <= '0;
        end else if (|hit_vec) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_fault <= denied(hit_w, hit_x, req_kind);
          resp_paddr <= denied(hit_w, hit_x, req_kind) ? '0 : {hit_fr, req_off};
        end else begin
          walking      <= 1'b1;
          mem_req_addr <= ptbase + MEM_AW'(req_pn);
        end
      end
      if (walking && mem_resp_valid) begin
        walking    <= 1'b0;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        if (!mem_resp_data[FRAME_W] ||
            denied(mem_resp_data[FRAME_W+1], mem_resp_data[FRAME_W+2], cur_kind)) begin
          resp_fault <= 1'b1;
          resp_paddr <= '0;
        end else begin
          resp_fault <= 1'b0;
          resp_paddr <= {mem_resp_data[FRAME_W-1:0], cur_off};
        end
      end
      if (refill) begin
        ent_v[rr]  <= 1'b1;
        ent_pn[rr] <= cur_pn;
        ent_fr[rr] <= mem_resp_data[FRAME_W-1:0];
        ent_w[rr]  <= mem_resp_data[FRAME_W+1];
        ent_x[rr]  <= mem_resp_data[FRAME_W+2];
        rr         <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7
  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !len_bad && (|hit_vec) |=> resp_valid && resp_hit && !mem_req_valid); // R2
  AST_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && len_bad |=> resp_valid && resp_fault && !mem_req_valid); // R4
  AST_WALK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_resp_valid |=> resp_valid && !resp_hit && !mem_req_valid); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !refill |=> ent_v == '0); // R8
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0); // R1
endmodule

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb_top;
  localparam int VA_W = 16, OFF_W = 8, FRAME_W = 8, MEM_AW = 16, ENTRIES = 8, LAT = 3;
  localparam int PN_W = VA_W - OFF_W;

  logic clk = 0, rst_n = 0, flush = 0, req_valid = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic [MEM_AW-1:0] ptbase = 16'h1000;
  logic [PN_W:0] ptlen = 9'd201;
  logic mem_resp_valid = 0;
  logic [FRAME_W+2:0] mem_resp_data = '0;
  logic req_ready, mem_req_valid, resp_valid, resp_fault, resp_hit;
  logic [MEM_AW-1:0] mem_req_addr;
  logic [FRAME_W+OFF_W-1:0] resp_paddr;

  always #4 clk = ~clk;

  tlb_walker #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW),
               .ENTRIES(ENTRIES)) dut_i (
    .clk, .rst_n, .flush, .req_valid, .req_ready, .req_vaddr, .req_kind,
    .ptbase, .ptlen, .mem_req_valid, .mem_req_addr, .mem_resp_valid,
    .mem_resp_data, .resp_valid, .resp_paddr, .resp_fault, .resp_hit);

  typedef struct packed {
    logic [FRAME_W+OFF_W-1:0] paddr;
    logic fault;
    logic hit;
  } exp_t;

  exp_t q[$];
  string tagq[$];
  int checks = 0, fails = 0, walks = 0;
  logic [MEM_AW-1:0] exp_maddr;
  bit done = 0;

  function automatic logic [FRAME_W+2:0] pte(input logic [PN_W-1:0] pn);
    return {pn[1], pn[0], pn[3:0] != 4'd3, pn ^ 8'hA5};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin : mem_model
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        walks++;
        check("R3 mem addr", mem_req_addr, exp_maddr);
        check("R9 ready low in walk", req_ready, 0);
        repeat (LAT) @(negedge clk);
        check("R3 req held", mem_req_valid, 1);
        mem_resp_data  = pte(PN_W'(mem_req_addr - ptbase));
        mem_resp_valid = 1;
        @(negedge clk);
        mem_resp_valid = 0;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (resp_valid) begin
        if (q.size() == 0) check("R2 unexpected result", 1, 0);
        else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = tagq.pop_front();
          check({t, " paddr"}, resp_paddr, e.paddr);
          check({t, " fault"}, resp_fault, e.fault);
          check({t, " hit"}, resp_hit, e.hit);
        end
      end
    end
  end

  task automatic xlate(input string tag, input logic [PN_W-1:0] pn,
                       input logic [OFF_W-1:0] off, input logic [1:0] kind,
                       input logic exp_hit);
    exp_t e;
    logic [FRAME_W+2:0] p;
    logic lenf, flt;
    int w0;
    p    = pte(pn);
    lenf = {1'b0, pn} >= ptlen;
    flt  = lenf || !p[FRAME_W] || (kind == 2'b01 && !p[FRAME_W+1]) ||
           (kind == 2'b10 && !p[FRAME_W+2]);
    e.hit   = !lenf && exp_hit;
    e.fault = flt;
    e.paddr = flt ? '0 : {p[FRAME_W-1:0], off};
    exp_maddr = ptbase + MEM_AW'(pn);
    w0 = walks;
    @(negedge clk);
    q.push_back(e);
    tagq.push_back(tag);
    check({tag, " R9 ready idle"}, req_ready, 1);
    req_vaddr = {pn, off};
    req_kind  = kind;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (q.size() != 0) @(negedge clk);
    check({tag, " walk count"}, walks - w0, (!lenf && !exp_hit) ? 1 : 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset ready", req_ready, 1);
    check("R9 reset resp", resp_valid, 0);
    check("R9 reset memreq", mem_req_valid, 0);

    xlate("R5 invalid pte", 8'd3, 8'h10, 2'b00, 0);
    xlate("R5 invalid not loaded", 8'd3, 8'h11, 2'b00, 0);
    xlate("R1 R3 miss read", 8'd1, 8'h3C, 2'b00, 0);
    xlate("R2 hit read", 8'd1, 8'hFF, 2'b00, 1);
    xlate("R6 hit write ok", 8'd1, 8'h00, 2'b01, 1);
    xlate("R6 hit exec denied", 8'd1, 8'h42, 2'b10, 1);
    xlate("R6 miss write denied", 8'd2, 8'h07, 2'b01, 0);
    xlate("R6 hit exec ok", 8'd2, 8'h08, 2'b10, 1);
    xlate("R6 kind 11 as read", 8'd2, 8'h09, 2'b11, 1);
    xlate("R4 last legal page", 8'd200, 8'hAB, 2'b00, 0);
    xlate("R4 length fault", 8'd201, 8'h01, 2'b00, 0);
    xlate("R4 length fault exec", 8'd255, 8'h02, 2'b10, 0);

    do_flush();
    xlate("R8 miss after flush", 8'd1, 8'h55, 2'b00, 0);
    xlate("R8 hit after refill", 8'd1, 8'h56, 2'b00, 1);

    do_flush();
    for (int i = 40; i < 48; i++) xlate("R7 fill", 8'(i), 8'(i), 2'b00, 0);
    xlate("R7 fill hit", 8'd45, 8'h99, 2'b00, 1);
    xlate("R7 evicting fill", 8'd48, 8'h12, 2'b00, 0);
    xlate("R7 survivor hits", 8'd41, 8'h34, 2'b00, 1);
    xlate("R7 oldest evicted", 8'd40, 8'h56, 2'b00, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule